// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave side of a three-wire serial port that gives a host access to a bank of 8-bit configuration registers. The host holds an active-low select line low for one frame. While it is low, the host clocks in a register address, then a direction bit, then one data byte, all on the serial data input. On a write frame the block stores the byte in the addressed register. On a read frame the block shifts the register's byte out on a separate serial data output, so the host can sample it while it keeps clocking.

The serial clock, select and data lines are not used as clocks. Each passes through a two-flop synchroniser into a system clock that runs at least four times as fast as the serial clock. Serial clock edges are found by comparing the synchronised clock with its value one system cycle earlier. Each frame carries exactly one address and one byte. The select line goes high between frames, and that resets the frame decoder.

Top module: `cfgser_port`

## Requirements
- R1: After reset every register holds 0x00 and the serial data output is low.
- R2: Each frame is sampled on rising serial clock edges as 16 bits. The first 7 bits are the address, most significant bit first. The 8th bit is the direction bit. The last 8 bits are the data byte, most significant bit first.
- R3: A direction bit of 1 makes a write: the data byte is loaded into the addressed register when the 16th bit is sampled.
- R4: A direction bit of 0 makes a read. The addressed register's byte appears on the serial output, most significant bit first. Each bit changes after a falling serial clock edge, starting with the falling edge that follows the direction bit, so the host samples each bit before the next rising edge. A read leaves the register unchanged.
- R5: The serial output is low whenever no read bit is being presented. This covers the idle time, all of a write frame, and the time after the 8th read bit has been shown.
- R6: If select goes high before the 16th bit, the frame is discarded and no register changes. The next frame is decoded from its first bit.
- R7: Serial clock edges after the 16th bit of a frame cause no further write and do not change any register.
- R8: A write changes only the addressed register. All the other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_sel_n | input | 1 | Active-low frame select from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial read data to the host |

## Verification
The assertions assume that every serial clock level, once synchronised, lasts at least two system cycles. They also assume that select changes only while the serial clock is low and well away from its edges, so that a falling edge and the later output update both happen while the synchronised clock is still low. The bench keeps to these assumptions. Each serial clock half period is ten system cycles. Data is changed together with the falling edge. Select is lowered several cycles before the first rising edge and raised only after a full low phase.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } cfgser_dir_e;

endpackage

// File: rtl/cfgser_sync.sv
module cfgser_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d;
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= RESET_VAL;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/cfgser_regbank.sv
module cfgser_regbank #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] mem_d;
    logic [DEPTH-1:0][DATA_W-1:0] mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/cfgser_frame.sv
module cfgser_frame
    import cfgser_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sel_n_s,
    input  logic              din_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              dout
);

    localparam int FRAME_BITS = ADDR_W + 1 + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int OCNT_W     = $clog2(DATA_W + 1);

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        cfgser_dir_e       dir;
        logic [DATA_W-1:0] data;
        logic              rd_act;
        logic [DATA_W-1:0] oshift;
        logic [OCNT_W-1:0] ocnt;
        logic              dout;
    } frame_st_t;

    frame_st_t st_d;
    frame_st_t st_q;
    logic      rise;
    logic      fall;
    logic      wr_d;

    always_comb begin
        st_d = st_q;
        wr_d = 1'b0;
        rise = sclk_s & ~st_q.sclk_prev;
        fall = ~sclk_s & st_q.sclk_prev;
        st_d.sclk_prev = sclk_s;

        if (sel_n_s) begin
            st_d.cnt    = '0;
            st_d.rd_act = 1'b0;
            st_d.ocnt   = '0;
            st_d.dout   = 1'b0;
        end else begin
            if (rise && (st_q.cnt < CNT_W'(FRAME_BITS))) begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt < CNT_W'(ADDR_W)) begin
                    st_d.addr = {st_q.addr[ADDR_W-2:0], din_s};
                end else if (st_q.cnt == CNT_W'(ADDR_W)) begin
                    st_d.dir = cfgser_dir_e'(din_s);
                    if (cfgser_dir_e'(din_s) == DIR_READ) begin
                        st_d.rd_act = 1'b1;
                        st_d.oshift = rd_data;
                        st_d.ocnt   = '0;
                    end
                end else begin
                    st_d.data = {st_q.data[DATA_W-2:0], din_s};
                    if ((st_q.cnt == CNT_W'(FRAME_BITS - 1)) && (st_q.dir == DIR_WRITE)) begin
                        wr_d = 1'b1;
                    end
                end
            end

            if (fall) begin
                if (st_q.rd_act && (st_q.ocnt < OCNT_W'(DATA_W))) begin
                    st_d.dout   = st_q.oshift[DATA_W-1];
                    st_d.oshift = {st_q.oshift[DATA_W-2:0], 1'b0};
                    st_d.ocnt   = st_q.ocnt + 1'b1;
                end else begin
                    st_d.dout   = 1'b0;
                    st_d.rd_act = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{
                sclk_prev: 1'b0,
                cnt:       '0,
                addr:      '0,
                dir:       DIR_READ,
                data:      '0,
                rd_act:    1'b0,
                oshift:    '0,
                ocnt:      '0,
                dout:      1'b0
            };
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr = st_q.addr;
    assign wr_en   = wr_d;
    assign wr_addr = st_q.addr;
    assign wr_data = {st_q.data[DATA_W-2:0], din_s};
    assign dout    = st_q.dout;

endmodule

// File: rtl/cfgser_port.sv
module cfgser_port #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_sel_n,
    input  logic ser_din,
    output logic ser_dout
);

    localparam int          LINES     = 3;
    localparam logic [2:0]  LINE_IDLE = 3'b010;

    logic [LINES-1:0]  lines_s;
    logic              sclk_s;
    logic              sel_n_s;
    logic              din_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    cfgser_sync #(
        .WIDTH     (LINES),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (LINE_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_din, ser_sel_n, ser_clk}),
        .sync_o  (lines_s)
    );

    assign sclk_s  = lines_s[0];
    assign sel_n_s = lines_s[1];
    assign din_s   = lines_s[2];

    cfgser_frame #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .sel_n_s (sel_n_s),
        .din_s   (din_s),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dout    (ser_dout)
    );

    cfgser_regbank #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/cfgser_port_chk.sv
module cfgser_port_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk_s,
    input logic sel_n_s,
    input logic wr_en,
    input logic ser_dout
);

    // R2
    sclk_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_s) |=> sclk_s);

    // R3
    write_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (sclk_s && !sel_n_s));

    // R4
    dout_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_dout != $past(ser_dout)) |-> (!sclk_s || sel_n_s));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> !ser_dout);

    // R6
    no_write_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |-> !wr_en);

    // R7
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

endmodule

bind cfgser_port cfgser_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (sclk_s),
    .sel_n_s  (sel_n_s),
    .wr_en    (wr_en),
    .ser_dout (ser_dout)
);

// File: tb/cfgser_port_bench.sv
module cfgser_port_bench;

    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_sel_n = 1'b1;
    logic ser_din = 1'b0;
    logic ser_dout;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cfgser_port u_cfgser_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_sel_n (ser_sel_n),
        .ser_din   (ser_din),
        .ser_dout  (ser_dout)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Sends nbits serial clocks; returns read byte, any high output seen
    // outside read bit slots, and the output level after the last fall.
    task automatic frame(input logic [6:0] a, input logic dir, input logic [7:0] d,
                         input int nbits, output logic [7:0] rd,
                         output logic stray, output logic tail);
        rd = 8'h00;
        stray = 1'b0;
        ser_sel_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i < 7) ser_din = a[6-i];
            else if (i == 7) ser_din = dir;
            else if (i < 16) ser_din = d[15-i];
            else ser_din = 1'b1;
            repeat (HALF) @(negedge clk);
            if (i >= 8 && i <= 15 && dir == 1'b0) rd[15-i] = ser_dout;
            else if (ser_dout) stray = 1'b1;
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        tail = ser_dout;
        ser_sel_n = 1'b1;
        ser_din = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] r;
        logic s;
        logic t;
        frame(a, 1'b1, d, 16, r, s, t);
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] v);
        logic s;
        logic t;
        frame(a, 1'b0, 8'h00, 16, v, s, t);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 output after reset", {7'd0, ser_dout}, 8'h00);
        rd(7'h00, v);
        chk("R1 reg 0x00 reset value", v, 8'h00);
        rd(7'h7F, v);
        chk("R1 reg 0x7F reset value", v, 8'h00);
    endtask

    task automatic t_write_read();
        logic [7:0] v;
        wr(7'h01, 8'h80);
        wr(7'h40, 8'h01);
        wr(7'h7F, 8'hA5);
        wr(7'h00, 8'h3C);
        rd(7'h01, v);
        chk("R2 R3 R4 msb only at 0x01", v, 8'h80);
        rd(7'h40, v);
        chk("R2 R3 R4 lsb only at 0x40", v, 8'h01);
        rd(7'h7F, v);
        chk("R3 R4 top address", v, 8'hA5);
        rd(7'h00, v);
        chk("R3 R4 bottom address", v, 8'h3C);
        rd(7'h00, v);
        chk("R4 read leaves register", v, 8'h3C);
        rd(7'h02, v);
        chk("R8 neighbour 0x02 untouched", v, 8'h00);
        rd(7'h41, v);
        chk("R8 neighbour 0x41 untouched", v, 8'h00);
        rd(7'h01, v);
        chk("R8 0x01 kept after later writes", v, 8'h80);
    endtask

    task automatic t_quiet();
        logic [7:0] r;
        logic s;
        logic t;
        chk("R5 idle output", {7'd0, ser_dout}, 8'h00);
        frame(7'h10, 1'b1, 8'hFF, 16, r, s, t);
        chk("R5 no output during write", {7'd0, s}, 8'h00);
        frame(7'h10, 1'b0, 8'h00, 16, r, s, t);
        chk("R4 read 0xFF", r, 8'hFF);
        chk("R5 low after 8th read bit", {7'd0, t}, 8'h00);
        chk("R5 low before read bits", {7'd0, s}, 8'h00);
    endtask

    task automatic t_abort();
        logic [7:0] r;
        logic s;
        logic t;
        logic [7:0] v;
        wr(7'h22, 8'h5A);
        frame(7'h22, 1'b1, 8'hFF, 12, r, s, t);
        rd(7'h22, v);
        chk("R6 aborted write discarded", v, 8'h5A);
        frame(7'h7F, 1'b1, 8'h00, 15, r, s, t);
        rd(7'h7F, v);
        chk("R6 abort at bit 15", v, 8'hA5);
        frame(7'h55, 1'b1, 8'hFF, 5, r, s, t);
        wr(7'h23, 8'h77);
        rd(7'h23, v);
        chk("R6 next frame decoded from bit 1", v, 8'h77);
    endtask

    task automatic t_extra();
        logic [7:0] r;
        logic s;
        logic t;
        logic [7:0] v;
        frame(7'h30, 1'b1, 8'hC3, 18, r, s, t);
        rd(7'h30, v);
        chk("R7 extra clocks after write", v, 8'hC3);
        rd(7'h31, v);
        chk("R7 R8 following address untouched", v, 8'h00);
        frame(7'h30, 1'b0, 8'h00, 19, r, s, t);
        chk("R7 read with extra clocks", r, 8'hC3);
        chk("R7 R5 output low on extra clocks", {7'd0, t}, 8'h00);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_read();
        t_quiet();
        t_abort();
        t_extra();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule